// File: doc/BRIEF.md
# Hiccup Protection and Supply Sequencer

This block sequences the supply of an off-line switching controller and applies its two latched fault protections. It watches digital flags from analog comparators: supply above the start threshold, supply below the restart level, supply below undervoltage lockout, drain above the mains start level, the overcurrent comparator and the low demag-current comparator. It also watches a per-switching-cycle strobe and the gate request from the modulator. From these it drives the high-voltage charger enable, the run enable and the gated switch output.

At power-up the charger fills the supply capacitor until the start threshold is reached. Switching is then enabled and the charger turns off. While running, the charger acts as a self-supply: it refills the capacitor only during switch off-time, once the supply has fallen below the restart level, and stops when the start threshold is reached again.

Overcurrent is filtered through a warning state. One bad switching cycle only warns, and a second consecutive bad cycle stops the device. A stop is latched and starves the supply. The latch clears only when the supply decays below undervoltage lockout. After that the charger still waits for the restart level before recharging, which gives low-frequency hiccup retries.

Top module: `hiccup_supply_seq`

## Requirements
- R1: After reset with all flags low, hv_charge_en, run_en, gate_out and fault_latched are 0 and status reads idle. The status encoding is 0 idle, 1 warning while running, 2 fault latched, 3 running.
- R2: hv_charge_en is never 1 unless the drain flag (drain_above_mains) has been high for the synchronizer latency. During start-up with the drain flag high and not yet running, hv_charge_en is 1.
- R3: Once vcc_above_start is seen during start-up, run_en becomes 1, hv_charge_en becomes 0 and status reads 3.
- R4: While running, after vcc_below_restart is seen, hv_charge_en equals the inverse of gate_out. It stays that way until vcc_above_start is seen, and is 0 otherwise.
- R5: gate_out equals gate_req while run_en is 1, and is 0 while run_en is 0.
- R6: A switching cycle with an overcurrent trip, closed by cycle_strobe, moves status from 3 to 1. A following cycle with no trip returns status to 3.
- R7: Two consecutive strobed cycles with overcurrent trips latch the fault: fault_latched is 1 and status is 2. run_en and hv_charge_en are 0 for as long as the latch holds, whatever the supply flags say.
- R8: The latch clears only when vcc_below_uvlo is seen. hv_charge_en then stays 0 until vcc_below_restart is also seen, after which start-up charging resumes.
- R9: A low demag current (brownout_low) seen while gate_out is 1 latches the fault at the next cycle_strobe. brownout_low seen while gate_out is 0 has no effect.
- R10: vcc_below_uvlo seen while running drops run_en and returns the block to start-up charging with status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_above_start | input | 1 | Supply at or above start threshold (async flag) |
| vcc_below_restart | input | 1 | Supply below restart level (async flag) |
| vcc_below_uvlo | input | 1 | Supply below undervoltage lockout (async flag) |
| drain_above_mains | input | 1 | Drain above mains start level (async flag) |
| ocp_trip | input | 1 | Overcurrent comparator output (async flag) |
| brownout_low | input | 1 | Demag source current below limit (async flag) |
| cycle_strobe | input | 1 | One-clock pulse closing each switching cycle |
| gate_req | input | 1 | Switch-on request from the modulator |
| gate_out | output | 1 | Gated switch drive |
| hv_charge_en | output | 1 | High-voltage charger enable |
| run_en | output | 1 | Switching enabled |
| fault_latched | output | 1 | Protection stop latched |
| status | output | 2 | 0 idle, 1 warning, 2 fault, 3 running |

## Verification
The hardest state to reach is the exact boundary of the warning filter. Trips must fall in consecutive strobed cycles, or in alternating ones, to separate "warn then idle" from "warn then latch". A fault must also be followed by the full supply decay sequence before the next run. The stimulus draws per-cycle trip and brownout decisions from a seeded generator. A bench model tracks the warning state and predicts each status, and every latched fault is walked through the undervoltage and restart flags in a fixed order, with charger checks at each step. Directed cycles cover brownout with the gate off, self-supply refill against gate activity, and the undervoltage drop while running.

// File: rtl/hiccup_seq_pkg.sv
package hiccup_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WARN  = 2'd1,
        ST_FAULT = 2'd2,
        ST_RUN   = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        SEQ_CHARGE = 2'd0,
        SEQ_RUN    = 2'd1,
        SEQ_FAULT  = 2'd2,
        SEQ_WAIT   = 2'd3
    } seq_e;

    typedef struct packed {
        logic mains_ok;
        logic vcc_start;
        logic vcc_restart;
        logic vcc_uvlo;
        logic ocp;
        logic brownout;
    } flags_t;

    localparam int SYNC_STAGES = 2;

    function automatic status_e make_status(logic fault, logic run, logic warn);
        if (fault)
            return ST_FAULT;
        else if (run)
            return warn ? ST_WARN : ST_RUN;
        else
            return ST_IDLE;
    endfunction

endpackage

// File: rtl/hiccup_flag_sync.sv
module hiccup_flag_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= '0;
                    else     stage[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= '0;
                    else     stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/hiccup_fault_guard.sv
module hiccup_fault_guard (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic strobe,
    input  logic ocp,
    input  logic brownout,
    input  logic gate_on,
    output logic warn,
    output logic fault_req
);
    logic seen_ocp;
    logic seen_bo;
    logic trip_cycle;
    logic bo_cycle;

    assign trip_cycle = seen_ocp | ocp;
    assign bo_cycle   = seen_bo | (brownout & gate_on);
    assign fault_req  = enable & strobe & ((warn & trip_cycle) | bo_cycle);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            seen_ocp <= 1'b0;
            seen_bo  <= 1'b0;
            warn     <= 1'b0;
        end else if (strobe) begin
            seen_ocp <= 1'b0;
            seen_bo  <= 1'b0;
            warn     <= trip_cycle & ~warn;
        end else begin
            seen_ocp <= trip_cycle;
            seen_bo  <= bo_cycle;
        end
    end
endmodule

// File: rtl/hiccup_supply_fsm.sv
module hiccup_supply_fsm
    import hiccup_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mains_ok,
    input  logic vcc_start,
    input  logic vcc_restart,
    input  logic vcc_uvlo,
    input  logic fault_req,
    input  logic gate_on,
    output logic run_en,
    output logic hv_charge_en,
    output logic fault_latched
);
    seq_e state;
    logic refill;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_CHARGE;
            refill <= 1'b0;
        end else begin
            case (state)
                SEQ_CHARGE: begin
                    refill <= 1'b0;
                    if (vcc_start) state <= SEQ_RUN;
                end
                SEQ_RUN: begin
                    if (fault_req) begin
                        state  <= SEQ_FAULT;
                        refill <= 1'b0;
                    end else if (vcc_uvlo) begin
                        state  <= SEQ_CHARGE;
                        refill <= 1'b0;
                    end else if (vcc_restart) begin
                        refill <= 1'b1;
                    end else if (vcc_start) begin
                        refill <= 1'b0;
                    end
                end
                SEQ_FAULT: begin
                    if (vcc_uvlo) state <= SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (vcc_restart) state <= SEQ_CHARGE;
                end
                default: state <= SEQ_CHARGE;
            endcase
        end
    end

    assign run_en        = (state == SEQ_RUN);
    assign fault_latched = (state == SEQ_FAULT);
    assign hv_charge_en  = mains_ok &
                           ((state == SEQ_CHARGE) ||
                            ((state == SEQ_RUN) && refill && !gate_on));
endmodule

// File: rtl/hiccup_supply_seq.sv
module hiccup_supply_seq
    import hiccup_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vcc_above_start,
    input  logic       vcc_below_restart,
    input  logic       vcc_below_uvlo,
    input  logic       drain_above_mains,
    input  logic       ocp_trip,
    input  logic       brownout_low,
    input  logic       cycle_strobe,
    input  logic       gate_req,
    output logic       gate_out,
    output logic       hv_charge_en,
    output logic       run_en,
    output logic       fault_latched,
    output logic [1:0] status
);
    localparam int FLAG_W = $bits(flags_t);

    flags_t raw_flags;
    flags_t sync_flags;
    logic   mains_s;
    logic   uvlo_s;
    logic   warn;
    logic   fault_req;

    assign raw_flags = '{mains_ok:    drain_above_mains,
                         vcc_start:   vcc_above_start,
                         vcc_restart: vcc_below_restart,
                         vcc_uvlo:    vcc_below_uvlo,
                         ocp:         ocp_trip,
                         brownout:    brownout_low};

    hiccup_flag_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_flags),
        .q   (sync_flags)
    );

    assign mains_s  = sync_flags.mains_ok;
    assign uvlo_s   = sync_flags.vcc_uvlo;
    assign gate_out = gate_req & run_en;

    hiccup_fault_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .enable    (run_en),
        .strobe    (cycle_strobe),
        .ocp       (sync_flags.ocp),
        .brownout  (sync_flags.brownout),
        .gate_on   (gate_out),
        .warn      (warn),
        .fault_req (fault_req)
    );

    hiccup_supply_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .mains_ok      (mains_s),
        .vcc_start     (sync_flags.vcc_start),
        .vcc_restart   (sync_flags.vcc_restart),
        .vcc_uvlo      (uvlo_s),
        .fault_req     (fault_req),
        .gate_on       (gate_out),
        .run_en        (run_en),
        .hv_charge_en  (hv_charge_en),
        .fault_latched (fault_latched)
    );

    assign status = make_status(fault_latched, run_en, warn);
endmodule

// File: rtl/hiccup_seq_chk.sv
module hiccup_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       run_en,
    input logic       hv_charge_en,
    input logic       fault_latched,
    input logic       gate_out,
    input logic       mains_s,
    input logic       uvlo_s,
    input logic [1:0] status
);
    assert_charge_needs_mains_R2: assert property (@(posedge clk) disable iff (rst)
        hv_charge_en |-> mains_s);

    assert_start_stops_charger_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(run_en) |-> !hv_charge_en);

    assert_gate_low_when_stopped_R5: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd0 || status == 2'd2) |-> !gate_out);

    assert_fault_silences_R7: assert property (@(posedge clk) disable iff (rst)
        fault_latched |-> (!run_en && !hv_charge_en));

    assert_fault_clears_on_uvlo_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_latched) |-> $past(uvlo_s));

    assert_fault_entry_from_run_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_latched) |-> $past(run_en));
endmodule

bind hiccup_supply_seq hiccup_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .run_en        (run_en),
    .hv_charge_en  (hv_charge_en),
    .fault_latched (fault_latched),
    .gate_out      (gate_out),
    .mains_s       (mains_s),
    .uvlo_s        (uvlo_s),
    .status        (status)
);

// File: tb/hiccup_supply_seq_tb.sv
module hiccup_supply_seq_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vcc_above_start = 0, vcc_below_restart = 0, vcc_below_uvlo = 0;
    logic drain_above_mains = 0, ocp_trip = 0, brownout_low = 0;
    logic cycle_strobe = 0, gate_req = 0;
    logic gate_out, hv_charge_en, run_en, fault_latched;
    logic [1:0] status;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit warn_m = 0;

    always #4 clk = ~clk;

    hiccup_supply_seq u_dut (
        .clk(clk), .rst(rst),
        .vcc_above_start(vcc_above_start), .vcc_below_restart(vcc_below_restart),
        .vcc_below_uvlo(vcc_below_uvlo), .drain_above_mains(drain_above_mains),
        .ocp_trip(ocp_trip), .brownout_low(brownout_low),
        .cycle_strobe(cycle_strobe), .gate_req(gate_req),
        .gate_out(gate_out), .hv_charge_en(hv_charge_en), .run_en(run_en),
        .fault_latched(fault_latched), .status(status)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_status(bit fault, bit warn);
        if (fault) return 2;
        return warn ? 1 : 3;
    endfunction

    task automatic do_cycle(bit trip, bit bo);
        gate_req = 1;
        ocp_trip = trip;
        brownout_low = bo;
        tick(5);
        ocp_trip = 0;
        brownout_low = 0;
        gate_req = 0;
        tick(5);
        cycle_strobe = 1;
        tick(1);
        cycle_strobe = 0;
        tick(3);
    endtask

    task automatic recover();
        vcc_above_start = 0;
        vcc_below_restart = 1;
        tick(5);
        check("R7 latch holds charger off", hv_charge_en, 0);
        check("R7 latch holds status", status, 2);
        vcc_below_restart = 0;
        vcc_below_uvlo = 1;
        tick(5);
        check("R8 uvlo clears latch", fault_latched, 0);
        check("R8 waits for restart", hv_charge_en, 0);
        vcc_below_restart = 1;
        tick(5);
        check("R8 recharge after restart", hv_charge_en, 1);
        vcc_below_uvlo = 0;
        vcc_below_restart = 0;
        vcc_above_start = 1;
        tick(5);
        check("R3 run after hiccup", run_en, 1);
        warn_m = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        tick(5);
        rst = 0;
        tick(3);
        // R1 reset state
        check("R1 charger", hv_charge_en, 0);
        check("R1 run", run_en, 0);
        check("R1 fault", fault_latched, 0);
        check("R1 status", status, 0);
        check("R1 gate", gate_out, 0);

        // R2 charger gated by mains
        vcc_below_restart = 1;
        tick(5);
        check("R2 no mains no charge", hv_charge_en, 0);
        drain_above_mains = 1;
        gate_req = 1;
        tick(5);
        check("R2 startup charge", hv_charge_en, 1);
        check("R5 gate low before run", gate_out, 0);
        gate_req = 0;

        // R3 start threshold
        vcc_below_restart = 0;
        vcc_above_start = 1;
        tick(5);
        check("R3 run enabled", run_en, 1);
        check("R3 charger off", hv_charge_en, 0);
        check("R3 status run", status, 3);

        // R5 gate follows request
        gate_req = 1;
        tick(1);
        check("R5 gate follows high", gate_out, 1);
        gate_req = 0;
        tick(1);
        check("R5 gate follows low", gate_out, 0);

        // R4 self-supply during off-time
        vcc_above_start = 0;
        vcc_below_restart = 1;
        tick(5);
        check("R4 refill off-time", hv_charge_en, 1);
        gate_req = 1;
        tick(1);
        check("R4 no refill on-time", hv_charge_en, 0);
        gate_req = 0;
        vcc_below_restart = 0;
        tick(5);
        check("R4 refill holds to start", hv_charge_en, 1);
        vcc_above_start = 1;
        tick(5);
        check("R4 refill ends at start", hv_charge_en, 0);

        // R6 warning then clean cycle
        do_cycle(1, 0);
        check("R6 warn after one trip", status, 1);
        do_cycle(0, 0);
        check("R6 back to run", status, 3);

        // R7 two consecutive trips
        do_cycle(1, 0);
        do_cycle(1, 0);
        check("R7 fault latched", fault_latched, 1);
        check("R7 run stopped", run_en, 0);
        recover();

        // R9 brownout ignored when gate off
        brownout_low = 1;
        tick(6);
        brownout_low = 0;
        tick(5);
        cycle_strobe = 1;
        tick(1);
        cycle_strobe = 0;
        tick(3);
        check("R9 brownout off-time ignored", status, 3);
        do_cycle(0, 1);
        check("R9 brownout on-time faults", status, 2);
        recover();

        // Random trip sequences against the model
        for (int i = 0; i < 80; i++) begin
            bit trip, bo, fault;
            trip = ($urandom % 3) == 0;
            bo = ($urandom % 12) == 0;
            fault = bo || (warn_m && trip);
            warn_m = !fault && trip && !warn_m;
            do_cycle(trip, bo);
            check(fault ? "R7 random fault" : "R6 random status", status,
                  exp_status(fault, warn_m));
            if (fault) recover();
        end

        // R10 uvlo while running
        vcc_above_start = 0;
        vcc_below_restart = 1;
        vcc_below_uvlo = 1;
        tick(5);
        check("R10 run dropped", run_en, 0);
        check("R10 status idle", status, 0);
        check("R10 startup charge", hv_charge_en, 1);
        drain_above_mains = 0;
        tick(5);
        check("R2 mains lost", hv_charge_en, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule